// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Core

This block is a synthesizable cycle model of a static memory with two data ports: one that only reads and one that only writes. One address bus serves both. The bus alternates between the two ports on successive rising clock edges, starting with a read slot after reset. Each address names a group of four words that always move together as one burst. The double-rate data pins are modelled as two words per clock cycle, so a burst takes two cycles on either port. The low half of a data bus carries the even-numbered word of the pair.

A read that is accepted in a read slot returns its burst a fixed two cycles later. A valid flag is high while burst data is on the output. Each port has its own active-low select, which is looked at only in that port's own slot. The data for a write follows its address over the next two cycles. A write reaches the array once the fourth word has arrived. A read that is accepted after such a write has been accepted sees the new data, even if the array has not yet been updated.

Top module: `qdrb_sram`

## Requirements
- R1: After reset the first rising edge is a read slot, and later slots alternate between read and write on every edge. `rd_slot` is high during a cycle whose closing edge is a read slot.
- R2: A read accepted at edge T puts words 0 and 1 on `rd_data` after edge T+2 and words 2 and 3 after edge T+3. Word k of a burst sits at bits [k*DW +: DW], and each data bus carries word 2j in bits [DW-1:0] and word 2j+1 in bits [2*DW-1:DW].
- R3: `rd_valid` is high in exactly the two output cycles of each accepted read, and `rd_data` is all zeros whenever `rd_valid` is low.
- R4: Reads accepted in consecutive read slots give output with no idle cycle between bursts, and `rd_valid` stays high across them.
- R5: For a write whose address is accepted at edge W, words 0/1 are taken from `wr_data` at edge W+1 and words 2/3 at edge W+2. The whole burst is stored at the address.
- R6: The selects are active low. A high select in its own slot means no operation: no read output appears, and memory stays unchanged whatever `wr_data` holds.
- R7: Each select matters only in its own port's slot. Its value in the other port's slot has no effect.
- R8: A read accepted one edge after a write to the same address returns the new burst, even though that write is still being committed.
- R9: A read accepted one edge before a write to the same address returns the old contents.
- R10: While reset is held, `rd_valid` is low, `rd_data` is zero and `rd_slot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Shared burst address, used by the port that owns the current slot |
| rd_sel_n | input | 1 | Read port select, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_data | input | 2*DW | Two write words per cycle |
| rd_data | output | 2*DW | Two read words per cycle |
| rd_valid | output | 1 | High while `rd_data` carries read data |
| rd_slot | output | 1 | High when the next edge samples a read request |

## Verification
A fault in the slot toggle shows on `rd_slot` at the first edge after reset, and it also drops or misroutes every later request. A wrong stage in the read pipeline shifts `rd_valid` or the data by one cycle, and the first accepted read after the fault shows it two or three cycles later. A corrupt write holding register or a bad forwarding compare does not show until a later read of that address. The bench narrows that gap with directed write-then-read pairs on a single address. It also runs random traffic over a few addresses, so that collisions are common and a bad stored value comes back within a few slots.

// File: rtl/qdrb_pkg.sv
package qdrb_pkg;

    // Words in one burst and the number of cycles one burst uses on a port.
    localparam int BURST_WORDS = 4;
    localparam int BEAT_WORDS  = 2;
    localparam int BEATS       = BURST_WORDS / BEAT_WORDS;

    // Owner of the shared address bus at the coming edge.
    typedef enum logic {
        SLOT_WRITE = 1'b0,
        SLOT_READ  = 1'b1
    } slot_e;

    function automatic slot_e slot_next(input slot_e cur);
        return (cur == SLOT_READ) ? SLOT_WRITE : SLOT_READ;
    endfunction

    // Output sequencer state of the read port.
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_FIRST = 2'd1,
        OUT_LAST  = 2'd2
    } outph_e;

endpackage

// File: rtl/qdrb_slot_ctrl.sv
module qdrb_slot_ctrl
    import qdrb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_sel_n,
    input  logic wr_sel_n,
    output logic slot_is_rd,
    output logic rd_req,
    output logic wr_req
);

    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_READ;
        end else begin
            slot_q <= slot_next(slot_q);
        end
    end

    // A select counts only in the slot that belongs to its port.
    always_comb begin
        slot_is_rd = (slot_q == SLOT_READ);
        rd_req     = slot_is_rd  && !rd_sel_n;
        wr_req     = !slot_is_rd && !wr_sel_n;
    end

endmodule

// File: rtl/qdrb_write_path.sv
module qdrb_write_path #(
    parameter int AW = 8,
    parameter int DW = 18,
    localparam int PW = 2 * DW,
    localparam int BW = 4 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] wr_data,
    output logic          cm_en,
    output logic [AW-1:0] cm_addr,
    output logic [BW-1:0] cm_burst
);

    // Stage A holds the accepted address, and stage B also holds words 0/1.
    logic          wa_vld_q, wb_vld_q;
    logic [AW-1:0] wa_addr_q, wb_addr_q;
    logic [PW-1:0] wb_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wa_vld_q <= 1'b0;
            wb_vld_q <= 1'b0;
        end else begin
            wa_vld_q <= wr_req;
            wb_vld_q <= wa_vld_q;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_req) begin
            wa_addr_q <= addr;
        end
        if (wa_vld_q) begin
            wb_addr_q <= wa_addr_q;
            wb_lo_q   <= wr_data;
        end
    end

    // Words 2/3 are on wr_data in the commit cycle, so the burst is complete here.
    always_comb begin
        cm_en    = wb_vld_q;
        cm_addr  = wb_addr_q;
        cm_burst = {wr_data, wb_lo_q};
    end

endmodule

// File: rtl/qdrb_array.sv
module qdrb_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 18,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = 4 * DW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [BW-1:0] wburst,
    input  logic [AW-1:0] raddr,
    output logic [BW-1:0] rburst
);

    // One storage lane per word position of the burst.
    for (genvar k = 0; k < qdrb_pkg::BURST_WORDS; k++) begin : g_lane
        logic [DW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we) begin
                lane_mem[waddr] <= wburst[k*DW +: DW];
            end
        end

        assign rburst[k*DW +: DW] = lane_mem[raddr];
    end

endmodule

// File: rtl/qdrb_read_path.sv
module qdrb_read_path
    import qdrb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18,
    localparam int PW = 2 * DW,
    localparam int BW = 4 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] arr_addr,
    input  logic [BW-1:0] arr_burst,
    input  logic          fw_en,
    input  logic [AW-1:0] fw_addr,
    input  logic [BW-1:0] fw_burst,
    output logic [PW-1:0] rd_data,
    output logic          rd_valid
);

    logic          ra_vld_q, rb_vld_q;
    logic [AW-1:0] ra_addr_q;
    logic [BW-1:0] burst_q;
    logic [BW-1:0] merged;
    logic [PW-1:0] hold_q, data_q;
    outph_e        ph_q;

    assign arr_addr = ra_addr_q;

    // The write that commits at this edge is not yet in the array.
    always_comb begin
        merged = arr_burst;
        if (fw_en && (fw_addr == ra_addr_q)) begin
            merged = fw_burst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_vld_q <= 1'b0;
            rb_vld_q <= 1'b0;
        end else begin
            ra_vld_q <= rd_req;
            rb_vld_q <= ra_vld_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_req) begin
            ra_addr_q <= addr;
        end
        if (ra_vld_q) begin
            burst_q <= merged;
        end
    end

    // The output sequencer sends the lower beat first and then the held upper beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= OUT_IDLE;
            data_q <= '0;
            hold_q <= '0;
        end else if (rb_vld_q) begin
            ph_q   <= OUT_FIRST;
            data_q <= burst_q[PW-1:0];
            hold_q <= burst_q[BW-1:PW];
        end else if (ph_q == OUT_FIRST) begin
            ph_q   <= OUT_LAST;
            data_q <= hold_q;
        end else begin
            ph_q   <= OUT_IDLE;
            data_q <= '0;
        end
    end

    assign rd_data  = data_q;
    assign rd_valid = (ph_q != OUT_IDLE);

endmodule

// File: rtl/qdrb_sram.sv
module qdrb_sram #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [PW-1:0] wr_data,
    output logic [PW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rd_slot
);

    localparam int BW = 4 * DW;

    logic          rd_req, wr_req;
    logic          cm_en;
    logic [AW-1:0] cm_addr, arr_raddr;
    logic [BW-1:0] cm_burst, arr_rburst;

    qdrb_slot_ctrl u_slot (
        .clk        (clk),
        .rst        (rst),
        .rd_sel_n   (rd_sel_n),
        .wr_sel_n   (wr_sel_n),
        .slot_is_rd (rd_slot),
        .rd_req     (rd_req),
        .wr_req     (wr_req)
    );

    qdrb_write_path #(.AW(AW), .DW(DW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .addr     (addr),
        .wr_data  (wr_data),
        .cm_en    (cm_en),
        .cm_addr  (cm_addr),
        .cm_burst (cm_burst)
    );

    qdrb_array #(.DEPTH(DEPTH), .DW(DW)) u_arr (
        .clk    (clk),
        .we     (cm_en),
        .waddr  (cm_addr),
        .wburst (cm_burst),
        .raddr  (arr_raddr),
        .rburst (arr_rburst)
    );

    qdrb_read_path #(.AW(AW), .DW(DW)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .addr      (addr),
        .arr_addr  (arr_raddr),
        .arr_burst (arr_rburst),
        .fw_en     (cm_en),
        .fw_addr   (cm_addr),
        .fw_burst  (cm_burst),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/qdrb_sram_chk.sv
module qdrb_sram_chk #(
    parameter int DW = 18,
    localparam int PW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_slot,
    input logic          rd_sel_n,
    input logic          rd_valid,
    input logic [PW-1:0] rd_data
);

    // History of accepted reads, seen only at the ports.
    logic req_d1, req_d2, req_d3, req_d4;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d1 <= 1'b0;
            req_d2 <= 1'b0;
            req_d3 <= 1'b0;
            req_d4 <= 1'b0;
        end else begin
            req_d1 <= rd_slot && !rd_sel_n;
            req_d2 <= req_d1;
            req_d3 <= req_d2;
            req_d4 <= req_d3;
        end
    end

    AST_SLOT_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_slot != $past(rd_slot))); // R1

    AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rd_valid == (req_d3 || req_d4)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R3

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (req_d3 && req_d1) |=> rd_valid); // R4

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!req_d3 && !req_d4) |-> !rd_valid); // R6

endmodule

bind qdrb_sram qdrb_sram_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_slot  (rd_slot),
    .rd_sel_n (rd_sel_n),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/qdrb_sram_bench.sv
`timescale 1ns/1ps
module qdrb_sram_bench;

    localparam int DW    = 18;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int PW    = 2 * DW;
    localparam int BW    = 4 * DW;
    localparam int MAXE  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [PW-1:0] wr_data = '0;
    logic [PW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_slot;

    always #2.5 clk = ~clk;

    qdrb_sram #(.DW(DW), .DEPTH(DEPTH)) u_qdrb_sram (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_slot  (rd_slot)
    );

    int checks = 0;
    int errors = 0;
    int e = 0;
    bit done = 1'b0;
    logic [BW-1:0] ref_mem [DEPTH];
    logic          exp_v [MAXE];
    logic [PW-1:0] exp_d [MAXE];
    logic [BW-1:0] wp_burst = '0;
    int            wp_stage = 0;

    function automatic logic [BW-1:0] rnd_burst();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[BW-1:0];
    endfunction

    function automatic logic [PW-1:0] rnd_beat();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[PW-1:0];
    endfunction

    task automatic chk_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s edge %0d actual %b expected %b", tag, what, e, act, exp);
        end
    endtask

    task automatic chk_data(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rd_data edge %0d actual %h expected %h", tag, e, act, exp);
        end
    endtask

    // Drives one edge, updates the reference, then checks the outputs after that edge.
    task automatic run_edge(input bit req, input logic [AW-1:0] a, input logic [BW-1:0] b, input string tag);
        bit is_rd;
        is_rd = (e % 2 == 0);
        addr  = a;
        if (is_rd) begin
            rd_sel_n = !req;
            wr_sel_n = $urandom() % 2 == 0;   // R7: off-slot select is a don't-care
        end else begin
            wr_sel_n = !req;
            rd_sel_n = $urandom() % 2 == 0;
        end
        if (wp_stage == 1)      wr_data = wp_burst[PW-1:0];
        else if (wp_stage == 2) wr_data = wp_burst[BW-1:PW];
        else                    wr_data = rnd_beat();
        if (wp_stage == 2)      wp_stage = 0;
        else if (wp_stage == 1) wp_stage = 2;
        if (req && is_rd) begin
            exp_v[e+2] = 1'b1;
            exp_d[e+2] = ref_mem[a][PW-1:0];
            exp_v[e+3] = 1'b1;
            exp_d[e+3] = ref_mem[a][BW-1:PW];
        end
        if (req && !is_rd) begin
            ref_mem[a] = b;
            wp_burst   = b;
            wp_stage   = 1;
        end
        @(posedge clk);
        @(negedge clk);
        chk_bit(tag, "rd_valid", rd_valid, exp_v[e]);
        chk_data(tag, rd_data, exp_d[e]);
        chk_bit("R1", "rd_slot", rd_slot, ((e + 1) % 2) == 0);
        e++;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BADF00D));
        for (int i = 0; i < MAXE; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R10: reset state
        chk_bit("R10", "rd_valid", rd_valid, 1'b0);
        chk_data("R10", rd_data, '0);
        chk_bit("R10", "rd_slot", rd_slot, 1'b1);
        rst = 1'b0;

        // R5: fill every address through the write port
        for (int i = 0; i < DEPTH; i++) begin
            run_edge(1'b0, '0, '0, "R5");
            run_edge(1'b1, AW'(i), rnd_burst(), "R5");
        end
        // R4: read everything back in consecutive read slots
        for (int i = 0; i < DEPTH; i++) begin
            run_edge(1'b1, AW'(i), '0, "R4");
            run_edge(1'b0, '0, '0, "R4");
        end
        // R8: read one edge after a write to the same address
        for (int i = 0; i < 16; i++) begin
            run_edge(1'b0, '0, '0, "R8");
            run_edge(1'b1, AW'(i * 7), rnd_burst(), "R8");
            run_edge(1'b1, AW'(i * 7), '0, "R8");
            run_edge(1'b0, '0, '0, "R8");
        end
        // R9: read one edge before a write to the same address
        for (int i = 0; i < 8; i++) begin
            run_edge(1'b1, AW'(i * 5), '0, "R9");
            run_edge(1'b1, AW'(i * 5), rnd_burst(), "R9");
            run_edge(1'b0, '0, '0, "R9");
            run_edge(1'b0, '0, '0, "R9");
            run_edge(1'b1, AW'(i * 5), '0, "R9");
            run_edge(1'b0, '0, '0, "R9");
        end
        // R6: deselected slots with garbage data, then read back
        for (int i = 0; i < 32; i++) begin
            run_edge(1'b0, AW'($urandom() % DEPTH), '0, "R6");
        end
        for (int i = 0; i < 8; i++) begin
            run_edge(1'b1, AW'(i), '0, "R6");
            run_edge(1'b0, AW'(i), '0, "R6");
        end
        // R7 with R2/R3: random traffic on a few addresses
        for (int i = 0; i < 2000; i++) begin
            run_edge(($urandom() % 4) != 0, AW'($urandom() % 8), rnd_burst(), "R7 R2/R3");
        end
        for (int i = 0; i < 6; i++) begin
            run_edge(1'b0, '0, '0, "R3");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule